// File: doc/BRIEF.md
# Double-Buffered Endpoint Buffer Controller

This block keeps the 32-bit control word of one device endpoint that alternates between two data buffers. It arbitrates who owns each buffer. Software hands a buffer over by writing the word through a plain register port. The serial engine then asks for the current buffer and receives one of three answers: go-ahead, not ready or stall. It also receives the buffer's length, data PID, last flag and start offset. When the transfer finishes, the engine posts completion status, which returns the buffer to software.

A one-bit selector names the current buffer. In double-buffered mode each accepted completion moves the selector to the other buffer. In single-buffered mode the selector stays on buffer 0. Software can force the selector back to buffer 0.

The second buffer starts at a fixed 64-byte offset from the first. On an isochronous endpoint the offset instead comes from a 2-bit code in the word.

Top module: `ep_dbuf_ctrl`

## Requirements
- R1: Reset clears the whole control word to zero and sets the selector to buffer 0.
- R2: A software write stores the written word. The exception is bit 12, the selector-reset bit: writing 1 to it returns the selector to buffer 0, and it always reads back as 0.
- R3: Buffer 0 uses the lower half of the word and buffer 1 the upper half. Within each half, length sits in bits 9:0, available in bit 10, PID in bit 13, last in bit 14 and full in bit 15. Bit 11 is stall. The offset code sits in bits 28:27. When the current buffer is available and stall is clear, a request is answered with go-ahead, and the current buffer's length, PID and last flag are presented.
- R4: A request while the current buffer is not available and stall is clear is answered with not ready. A completion in that cycle is ignored, and the word and the selector stay unchanged.
- R5: While stall is set, every request is answered with stall, whichever buffer is selected. Completions are ignored.
- R6: An accepted completion clears the available bit of the current buffer. On an OUT endpoint it also loads that buffer's length with the received byte count and sets its full bit. On an IN endpoint the length and full bits stay as they were.
- R7: After an accepted completion the selector moves to the other buffer in double-buffered mode, and stays at buffer 0 in single-buffered mode.
- R8: The presented start offset is 0 for buffer 0. For buffer 1 it is 64 on a non-isochronous endpoint, and 128 shifted left by the offset code on an isochronous endpoint (codes 0 to 3 give 128, 256, 512 and 1024).
- R9: When a software write and an accepted completion fall in the same cycle, the engine's changes win for the current buffer's available, length and full fields. The software value applies to every other field. A selector reset in that write wins over the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_double | input | 1 | 1 selects double-buffered mode |
| cfg_iso | input | 1 | 1 marks an isochronous endpoint |
| cfg_dir_in | input | 1 | 1 marks an IN endpoint, 0 an OUT endpoint |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Current control word |
| eng_req | input | 1 | Engine requests the current buffer |
| eng_done | input | 1 | Engine posts completion status for the current buffer |
| eng_rx_len | input | 10 | Received byte count for OUT completion |
| eng_ack | output | 1 | Go-ahead answer |
| eng_nak | output | 1 | Not-ready answer |
| eng_stall | output | 1 | Stall answer |
| eng_sel | output | 1 | Current buffer index |
| eng_len | output | 10 | Length of the current buffer |
| eng_pid | output | 1 | Data PID of the current buffer |
| eng_last | output | 1 | Last flag of the current buffer |
| eng_offset | output | 11 | Start offset of the current buffer in bytes |

## Verification
The bench posts a completion on a buffer that is not available, and one while stall is set. A design that accepted either would clear bits, change the length or move the selector where the word must stay frozen.

It lands a software write and a completion in the same cycle. A design with the wrong priority would leave the buffer marked available, or lose the received length.

It also checks the following:
- Single-buffered mode, where a wrongly toggling selector would send the engine to buffer 1.
- An IN completion, which must not overwrite the length or full bits.
- Every isochronous offset code against the fixed non-isochronous offset, where a swapped decode shows up as a wrong start address.

// File: rtl/ep_dbuf_pkg.sv
package ep_dbuf_pkg;
    localparam int WORD_W     = 32;
    localparam int NBUF       = 2;
    localparam int HALF_W     = WORD_W / NBUF;
    localparam int LEN_W      = 10;
    localparam int POS_AVAIL  = 10;
    localparam int POS_STALL  = 11;
    localparam int POS_SELRST = 12;
    localparam int POS_PID    = 13;
    localparam int POS_LAST   = 14;
    localparam int POS_FULL   = 15;
    localparam int POS_OFSCODE = 27;
    localparam int OFSCODE_W  = 2;
    localparam int BASE_OFS   = 64;
    localparam int ISO_OFS    = 128;
    localparam int OFF_W      = $clog2(ISO_OFS << ((1 << OFSCODE_W) - 1)) + 1;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              sel;
    } ctl_state_t;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             avail;
        logic             pid;
        logic             last;
        logic             full;
    } buf_view_t;

    // Engine update of the fields owned by buffer b.
    function automatic logic [WORD_W-1:0] apply_done(
        input logic [WORD_W-1:0] w_in,
        input logic              b,
        input logic              dir_in,
        input logic [LEN_W-1:0]  rx_len
    );
        logic [WORD_W-1:0] w;
        int unsigned       base;
        w    = w_in;
        base = b ? HALF_W : 0;
        w[base + POS_AVAIL] = 1'b0;
        if (!dir_in) begin
            w[base +: LEN_W]   = rx_len;
            w[base + POS_FULL] = 1'b1;
        end
        return w;
    endfunction
endpackage

// File: rtl/ep_dbuf_view.sv
module ep_dbuf_view
    import ep_dbuf_pkg::*;
(
    input  logic [WORD_W-1:0]           word,
    output buf_view_t [NBUF-1:0]        views
);
    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        localparam int BASE = b * HALF_W;
        assign views[b].len   = word[BASE +: LEN_W];
        assign views[b].avail = word[BASE + POS_AVAIL];
        assign views[b].pid   = word[BASE + POS_PID];
        assign views[b].last  = word[BASE + POS_LAST];
        assign views[b].full  = word[BASE + POS_FULL];
    end
endmodule

// File: rtl/ep_dbuf_resp.sv
module ep_dbuf_resp
    import ep_dbuf_pkg::*;
(
    input  logic                  req,
    input  logic                  sel,
    input  logic                  stall_bit,
    input  logic                  iso,
    input  logic [OFSCODE_W-1:0]  ofs_code,
    input  buf_view_t [NBUF-1:0]  views,
    output logic                  cur_avail,
    output logic                  ack,
    output logic                  nak,
    output logic                  stall,
    output logic [LEN_W-1:0]      len,
    output logic                  pid,
    output logic                  last,
    output logic [OFF_W-1:0]      offset
);
    buf_view_t cur;

    always_comb begin
        cur       = views[sel];
        cur_avail = cur.avail;
        len       = cur.len;
        pid       = cur.pid;
        last      = cur.last;
        stall     = req && stall_bit;
        ack       = req && !stall_bit && cur.avail;
        nak       = req && !stall_bit && !cur.avail;
        if (!sel) begin
            offset = '0;
        end else if (iso) begin
            offset = OFF_W'(ISO_OFS) << ofs_code;
        end else begin
            offset = OFF_W'(BASE_OFS);
        end
    end
endmodule

// File: rtl/ep_dbuf_ctrl.sv
module ep_dbuf_ctrl
    import ep_dbuf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_double,
    input  logic                 cfg_iso,
    input  logic                 cfg_dir_in,
    input  logic                 sw_we,
    input  logic [WORD_W-1:0]    sw_wdata,
    output logic [WORD_W-1:0]    sw_rdata,
    input  logic                 eng_req,
    input  logic                 eng_done,
    input  logic [LEN_W-1:0]     eng_rx_len,
    output logic                 eng_ack,
    output logic                 eng_nak,
    output logic                 eng_stall,
    output logic                 eng_sel,
    output logic [LEN_W-1:0]     eng_len,
    output logic                 eng_pid,
    output logic                 eng_last,
    output logic [OFF_W-1:0]     eng_offset
);
    ctl_state_t           st_d, st_q;
    buf_view_t [NBUF-1:0] views;
    logic                 cur_avail;
    logic                 accept;

    ep_dbuf_view u_view (
        .word  (st_q.word),
        .views (views)
    );

    ep_dbuf_resp u_resp (
        .req       (eng_req),
        .sel       (st_q.sel),
        .stall_bit (st_q.word[POS_STALL]),
        .iso       (cfg_iso),
        .ofs_code  (st_q.word[POS_OFSCODE +: OFSCODE_W]),
        .views     (views),
        .cur_avail (cur_avail),
        .ack       (eng_ack),
        .nak       (eng_nak),
        .stall     (eng_stall),
        .len       (eng_len),
        .pid       (eng_pid),
        .last      (eng_last),
        .offset    (eng_offset)
    );

    always_comb begin
        st_d   = st_q;
        accept = eng_done && cur_avail && !st_q.word[POS_STALL];
        if (sw_we) begin
            st_d.word             = sw_wdata;
            st_d.word[POS_SELRST] = 1'b0;
        end
        if (accept) begin
            st_d.word = apply_done(st_d.word, st_q.sel, cfg_dir_in, eng_rx_len);
            st_d.sel  = cfg_double ? ~st_q.sel : 1'b0;
        end
        if (sw_we && sw_wdata[POS_SELRST]) begin
            st_d.sel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sw_rdata = st_q.word;
    assign eng_sel  = st_q.sel;
endmodule

// File: rtl/ep_dbuf_chk.sv
module ep_dbuf_chk
    import ep_dbuf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_double,
    input logic              sw_we,
    input logic [WORD_W-1:0] sw_wdata,
    input logic [WORD_W-1:0] sw_rdata,
    input logic              eng_req,
    input logic              eng_done,
    input logic              eng_ack,
    input logic              eng_nak,
    input logic              eng_stall,
    input logic              eng_sel,
    input logic [OFF_W-1:0]  eng_offset
);
    // R2: selector reset returns to buffer 0 and is not stored
    a_r2_selrst: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we && sw_wdata[POS_SELRST] |=> !eng_sel && !sw_rdata[POS_SELRST]);

    // R3: at most one answer per cycle
    a_r3_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_ack, eng_nak, eng_stall}));

    // R4: a not-ready cycle leaves the state frozen
    a_r4_nak_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        eng_nak && !sw_we |=> $stable(sw_rdata) && $stable(eng_sel));

    // R5: a stalled cycle leaves the state frozen
    a_r5_stall_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        eng_stall && !sw_we |=> $stable(sw_rdata) && $stable(eng_sel));

    // R6: accepted completion clears the current buffer's available bit
    a_r6_clear_b0: assert property (@(posedge clk) disable iff (!rst_n)
        eng_ack && eng_done && !eng_sel |=> !sw_rdata[POS_AVAIL]);
    a_r6_clear_b1: assert property (@(posedge clk) disable iff (!rst_n)
        eng_ack && eng_done && eng_sel |=> !sw_rdata[HALF_W + POS_AVAIL]);

    // R7: selector toggles in double mode, stays at 0 in single mode
    a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_double && eng_ack && eng_done && !(sw_we && sw_wdata[POS_SELRST])
        |=> eng_sel != $past(eng_sel));
    a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_double && eng_ack && eng_done |=> !eng_sel);

    // R8: buffer 0 always starts at offset 0
    a_r8_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_sel |-> eng_offset == '0);
endmodule

bind ep_dbuf_ctrl ep_dbuf_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_double (cfg_double),
    .sw_we      (sw_we),
    .sw_wdata   (sw_wdata),
    .sw_rdata   (sw_rdata),
    .eng_req    (eng_req),
    .eng_done   (eng_done),
    .eng_ack    (eng_ack),
    .eng_nak    (eng_nak),
    .eng_stall  (eng_stall),
    .eng_sel    (eng_sel),
    .eng_offset (eng_offset)
);

// File: tb/sim_ep_dbuf_ctrl.sv
module sim_ep_dbuf_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_double = 1'b0, cfg_iso = 1'b0, cfg_dir_in = 1'b0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        eng_req = 1'b0, eng_done = 1'b0;
    logic [9:0]  eng_rx_len = '0;
    logic        eng_ack, eng_nak, eng_stall, eng_sel, eng_pid, eng_last;
    logic [9:0]  eng_len;
    logic [10:0] eng_offset;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ep_dbuf_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_double(cfg_double), .cfg_iso(cfg_iso),
        .cfg_dir_in(cfg_dir_in), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .eng_req(eng_req), .eng_done(eng_done),
        .eng_rx_len(eng_rx_len), .eng_ack(eng_ack), .eng_nak(eng_nak),
        .eng_stall(eng_stall), .eng_sel(eng_sel), .eng_len(eng_len),
        .eng_pid(eng_pid), .eng_last(eng_last), .eng_offset(eng_offset)
    );

    typedef struct packed {
        logic        we;
        logic [31:0] wdata;
        logic        req;
        logic        done;
        logic [9:0]  rx;
        logic [2:0]  resp;   // {ack, nak, stall} before the edge
        logic [10:0] off;    // offset before the edge
        logic [31:0] word;   // word after the edge
        logic        sel;    // selector after the edge
    } vec_t;

    // Run with double-buffered, isochronous, OUT endpoint.
    localparam vec_t VECS [10] = '{
        '{1'b1, 32'h1400_0400, 1'b0, 1'b0, 10'h000, 3'b000, 11'd0,   32'h1400_0400, 1'b0}, // R2 store
        '{1'b0, 32'h0,         1'b1, 1'b1, 10'h040, 3'b100, 11'd0,   32'h1400_8040, 1'b1}, // R3 R6 R7 b0
        '{1'b0, 32'h0,         1'b1, 1'b1, 10'h3FF, 3'b100, 11'd512, 32'h93FF_8040, 1'b0}, // R8 R6 b1
        '{1'b0, 32'h0,         1'b1, 1'b1, 10'h005, 3'b010, 11'd0,   32'h93FF_8040, 1'b0}, // R4 nak
        '{1'b1, 32'h0000_0800, 1'b0, 1'b0, 10'h000, 3'b000, 11'd0,   32'h0000_0800, 1'b0}, // R2 stall set
        '{1'b0, 32'h0,         1'b1, 1'b1, 10'h022, 3'b001, 11'd0,   32'h0000_0800, 1'b0}, // R5 stall
        '{1'b1, 32'h0000_0400, 1'b0, 1'b0, 10'h000, 3'b000, 11'd0,   32'h0000_0400, 1'b0}, // R2
        '{1'b1, 32'h0400_0423, 1'b1, 1'b1, 10'h011, 3'b100, 11'd0,   32'h0400_8011, 1'b1}, // R9 collision
        '{1'b1, 32'h0400_1000, 1'b0, 1'b0, 10'h000, 3'b000, 11'd128, 32'h0400_0000, 1'b0}, // R2 sel reset
        '{1'b0, 32'h0,         1'b1, 1'b0, 10'h000, 3'b010, 11'd0,   32'h0400_0000, 1'b0}  // R4 nak
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic drive(input logic we, input logic [31:0] wd, input logic req,
                         input logic done, input logic [9:0] rx);
        @(negedge clk);
        sw_we = we; sw_wdata = wd; eng_req = req; eng_done = done; eng_rx_len = rx;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sw_we = 1'b0; eng_req = 1'b0; eng_done = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 word at reset", sw_rdata, 32'h0);
        chk("R1 sel at reset", {31'b0, eng_sel}, 32'h0);
        rst_n = 1'b1;

        cfg_double = 1'b1; cfg_iso = 1'b1; cfg_dir_in = 1'b0;
        for (int i = 0; i < 10; i++) begin
            drive(VECS[i].we, VECS[i].wdata, VECS[i].req, VECS[i].done, VECS[i].rx);
            chk($sformatf("R3 R4 R5 response v%0d", i),
                {29'b0, eng_ack, eng_nak, eng_stall}, {29'b0, VECS[i].resp});
            chk($sformatf("R8 offset v%0d", i), {21'b0, eng_offset}, {21'b0, VECS[i].off});
            tick();
            chk($sformatf("R2 R6 R9 word v%0d", i), sw_rdata, VECS[i].word);
            chk($sformatf("R7 sel v%0d", i), {31'b0, eng_sel}, {31'b0, VECS[i].sel});
        end

        // R7: single-buffered mode keeps buffer 0
        do_reset();
        cfg_double = 1'b0; cfg_iso = 1'b0; cfg_dir_in = 1'b0;
        drive(1'b1, 32'h0000_0400, 1'b0, 1'b0, 10'h0);
        tick();
        drive(1'b0, 32'h0, 1'b1, 1'b1, 10'h003);
        chk("R3 ack single", {31'b0, eng_ack}, 32'h1);
        tick();
        chk("R7 sel single", {31'b0, eng_sel}, 32'h0);
        chk("R6 OUT word single", sw_rdata, 32'h0000_8003);

        // R6: IN completion keeps length and full
        do_reset();
        cfg_double = 1'b1; cfg_dir_in = 1'b1;
        drive(1'b1, 32'h0000_E407, 1'b0, 1'b0, 10'h0);
        tick();
        drive(1'b0, 32'h0, 1'b1, 1'b1, 10'h3AA);
        chk("R3 len", {22'b0, eng_len}, 32'h7);
        chk("R3 pid last", {30'b0, eng_pid, eng_last}, 32'h3);
        tick();
        chk("R6 IN word", sw_rdata, 32'h0000_E007);
        chk("R7 sel after IN", {31'b0, eng_sel}, 32'h1);

        // R8: offsets for buffer 1
        cfg_iso = 1'b0;
        drive(1'b1, 32'h1800_0000, 1'b0, 1'b0, 10'h0);
        tick();
        chk("R8 non-iso offset", {21'b0, eng_offset}, 32'd64);
        cfg_iso = 1'b1;
        for (int c = 0; c < 4; c++) begin
            drive(1'b1, 32'(c) << 27, 1'b0, 1'b0, 10'h0);
            tick();
            chk($sformatf("R8 iso code %0d", c), {21'b0, eng_offset}, 32'd128 << c);
        end

        // R1: reset from a non-zero state
        drive(1'b1, 32'hFFFF_EFFF, 1'b0, 1'b0, 10'h0);
        tick();
        do_reset();
        #1;
        chk("R1 word after reset", sw_rdata, 32'h0);
        chk("R1 sel after reset", {31'b0, eng_sel}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule